// File: doc/BRIEF.md
# Seconds Counter with Alarm

This peripheral keeps a free-running count of seconds behind a small word-addressed register bus. Software loads a starting value, turns the counter on, and the count then steps by one on every cycle where the one-second tick input is high. The tick itself comes from outside. A select bit for the reference clock is held in the control register and driven out to the clock-selection logic that sits next to the block.

One alarm comparator watches the count. On a tick where the count equals the programmed alarm value, a sticky status bit is set. An interrupt line follows that bit, but only while the alarm is enabled and not masked. Software clears the status by writing a one to the clear register. After servicing an alarm, software writes zero to the alarm value so that it does not fire again.

A build-time parameter stores both the count and the alarm value in reflected binary (Gray) code. In that mode the counter steps through the Gray sequence, and the values on the bus are the stored codes.

Top module: `sec_alarm_timer`

## Requirements
- R1: After a synchronous active-low reset, the interrupt mask reads 1, and the control word, count, alarm value and status all read 0. The interrupt output is low.
- R2: The control word at byte offset 0x00 keeps bit 0 (alarm enable), bit 8 (reference select, 1 = fast reference) and bit 12 (count enable). All other bits read 0. Bit 8 drives `ref_sel_o`.
- R3: A write to offset 0x04 loads the count, and the new value reads back at offsets 0x34 and 0x04 on the next cycle. A load in the same cycle as a tick wins over the increment.
- R4: With bit 12 set, each cycle with `tick_i` high advances the count by one step. With bit 12 clear, or with no tick, the count holds.
- R5: In binary mode the count wraps from 0xFFFFFFFF to 0.
- R6: With `GRAY_CODED` = 1, each step moves the stored code g to the Gray code of (binary value of g) + 1, where Gray(b) = b ^ (b >> 1). Starting from 0, five ticks give 0x7.
- R7: Status bit 0 at offset 0x30 is set on a tick where alarm enable is 1 and the count equals the alarm value at 0x08. It stays set until it is cleared.
- R8: An alarm value of 0 never sets the status.
- R9: `irq_o` is high exactly when status bit 0 is 1, alarm enable is 1, and mask bit 0 at offset 0x20 is 0.
- R10: Writing a word with bit 0 = 1 to offset 0x24 clears the status. A word with bit 0 = 0 has no effect. A new alarm hit in the same cycle as a clear keeps the status set.
- R11: Offsets 0x30 and 0x34 are read-only. Unmapped and unaligned addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-second tick, one cycle wide |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| ref_sel_o | output | 1 | Reference clock select |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
A wrong count shows up on the time register in the cycle after the tick that caused it, so the reference model catches it within one clock. A status bit that is set or cleared on the wrong cycle shows on `irq_o` at once whenever the alarm is enabled and unmasked. It also shows on the status register the next time that register is read. A wrong Gray step would leave a code that stays wrong on every later read, because each step builds on the one before.

// File: rtl/sat_pkg.sv
// Package for the seconds counter with alarm.
// Holds the register word indices, the control bit positions and the control field type.
// Assumes the byte address is word-aligned, so the word index is bus_addr[ADDR_W-1:2].
package sat_pkg;
    localparam int IDX_CTRL   = 0;
    localparam int IDX_LOAD   = 1;
    localparam int IDX_ALARM  = 2;
    localparam int IDX_MASK   = 8;
    localparam int IDX_CLEAR  = 9;
    localparam int IDX_STATUS = 12;
    localparam int IDX_TIME   = 13;

    localparam int BIT_ALARM_EN = 0;
    localparam int BIT_REF_SEL  = 8;
    localparam int BIT_RUN      = 12;

    typedef struct packed {
        logic run;
        logic ref_sel;
        logic alarm_en;
    } ctrl_t;
endpackage

// File: rtl/sat_regs.sv
// Register file: decodes writes, holds the control word, alarm value and mask,
// produces the load and clear strobes, and muxes read data.
// Assumes at most one write per cycle. Reads are combinational.
module sat_regs
    import sat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic              stat_i,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] alarm_o,
    output logic              mask_o,
    output logic              load_we_o,
    output logic              clr_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic              aligned;
    logic [IDX_W-1:0]  idx;
    logic              wr_ctrl, wr_alarm, wr_mask;

    // Split the address into the alignment check and the word index.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        idx     = bus_addr[ADDR_W-1:2];
    end

    // Decode the write strobes for each register.
    always_comb begin
        wr_ctrl   = bus_we && aligned && (idx == IDX_W'(IDX_CTRL));
        wr_alarm  = bus_we && aligned && (idx == IDX_W'(IDX_ALARM));
        wr_mask   = bus_we && aligned && (idx == IDX_W'(IDX_MASK));
        load_we_o = bus_we && aligned && (idx == IDX_W'(IDX_LOAD));
        clr_o     = bus_we && aligned && (idx == IDX_W'(IDX_CLEAR)) && bus_wdata[0];
    end

    // Hold the control word, alarm value and mask. Reset leaves the alarm masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o  <= '0;
            alarm_o <= '0;
            mask_o  <= 1'b1;
        end else begin
            if (wr_ctrl) begin
                ctrl_o.alarm_en <= bus_wdata[BIT_ALARM_EN];
                ctrl_o.ref_sel  <= bus_wdata[BIT_REF_SEL];
                ctrl_o.run      <= bus_wdata[BIT_RUN];
            end
            if (wr_alarm) alarm_o <= bus_wdata;
            if (wr_mask)  mask_o  <= bus_wdata[0];
        end
    end

    // Select the read data. Unmapped and unaligned addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (idx == IDX_W'(IDX_CTRL)) begin
                bus_rdata[BIT_ALARM_EN] = ctrl_o.alarm_en;
                bus_rdata[BIT_REF_SEL]  = ctrl_o.ref_sel;
                bus_rdata[BIT_RUN]      = ctrl_o.run;
            end else if (idx == IDX_W'(IDX_LOAD) || idx == IDX_W'(IDX_TIME)) begin
                bus_rdata = cnt_i;
            end else if (idx == IDX_W'(IDX_ALARM)) begin
                bus_rdata = alarm_o;
            end else if (idx == IDX_W'(IDX_MASK)) begin
                bus_rdata[0] = mask_o;
            end else if (idx == IDX_W'(IDX_STATUS)) begin
                bus_rdata[0] = stat_i;
            end
        end
    end

    // R1: the mask is set in the cycle after reset.
    a_r1_mask_reset: assert property (@(posedge clk) !rst_n |=> mask_o);
    // R2: the control word changes only on a write.
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(ctrl_o));
endmodule

// File: rtl/sat_counter.sv
// Seconds counter: loads from the bus and steps once per enabled tick.
// GRAY_CODED picks a binary or a Gray-code step. A load wins over a tick.
// Assumes the tick is one cycle wide per second.
module sat_counter #(
    parameter int DATA_W     = 32,
    parameter bit GRAY_CODED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              load_we_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [DATA_W-1:0] cnt_q
);
    logic [DATA_W-1:0] inc_val;

    // Convert a Gray code to binary by xor-ing down from the top bit.
    function automatic logic [DATA_W-1:0] gray2bin(input logic [DATA_W-1:0] g);
        logic [DATA_W-1:0] b;
        b[DATA_W-1] = g[DATA_W-1];
        for (int i = DATA_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    generate
        if (GRAY_CODED) begin : g_gray
            logic [DATA_W-1:0] bin_next;
            // Step the Gray code: decode, add one, encode again.
            always_comb begin
                bin_next = gray2bin(cnt_q) + 1'b1;
                inc_val  = bin_next ^ (bin_next >> 1);
            end
            // R6: one enabled step changes exactly one bit.
            a_r6_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_i && run_i && !load_we_i) |=> $countones(cnt_q ^ $past(cnt_q)) == 1);
        end else begin : g_bin
            // Plain binary increment.
            always_comb inc_val = cnt_q + 1'b1;
            // R5: all ones wraps to zero.
            a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_i && run_i && !load_we_i && (&cnt_q)) |=> (cnt_q == '0));
        end
    endgenerate

    // Update the count: reset, load, or step on an enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load_we_i)         cnt_q <= load_val_i;
        else if (tick_i && run_i)   cnt_q <= inc_val;
    end

    // R3: a load shows on the next cycle.
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_we_i |=> (cnt_q == $past(load_val_i)));
    // R4: the count holds without an enabled tick.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_we_i && !(tick_i && run_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/sat_alarm.sv
// Alarm compare and interrupt: sets a sticky status on a matching tick and
// gates the interrupt with the enable and mask bits.
// Assumes the count and the alarm value use the same encoding, so equality holds in either code.
module sat_alarm #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              alarm_en_i,
    input  logic              mask_i,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic [DATA_W-1:0] alarm_i,
    input  logic              clr_i,
    output logic              stat_o,
    output logic              irq_o
);
    logic armed, hit;

    // Detect a hit: enabled, armed (nonzero alarm), on a tick, with equal values.
    always_comb begin
        armed = (alarm_i != '0);
        hit   = tick_i && alarm_en_i && armed && (cnt_i == alarm_i);
    end

    // Sticky status. A new hit wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_o <= 1'b0;
        else        stat_o <= hit || (stat_o && !clr_i);
    end

    // Drive the interrupt line from the status, the enable and the mask.
    always_comb irq_o = stat_o && alarm_en_i && !mask_i;

    // R7: a status bit, once set, stays set until a clear.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !clr_i) |=> stat_o);
    // R8: an alarm of zero never raises the status.
    a_r8_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_i == '0 && !stat_o) |=> !stat_o);
    // R9: a masked or disabled alarm keeps the line low.
    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i || !alarm_en_i) |-> !irq_o);
    // R10: the status falls only after a clear.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_o) |-> $past(clr_i));
endmodule

// File: rtl/sec_alarm_timer.sv
// Top level of the seconds counter with alarm.
// Wires the register file, the counter and the alarm. Drives the reference
// select to the clock-selection logic outside the block.
// Assumes a single-cycle bus with a combinational read path.
module sec_alarm_timer
    import sat_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 6,
    parameter bit GRAY_CODED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ref_sel_o,
    output logic              irq_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] alarm_val, cnt;
    logic              mask, load_we, clr, stat;

    sat_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt_i(cnt), .stat_i(stat), .bus_rdata(bus_rdata),
        .ctrl_o(ctrl), .alarm_o(alarm_val), .mask_o(mask),
        .load_we_o(load_we), .clr_o(clr)
    );

    sat_counter #(.DATA_W(DATA_W), .GRAY_CODED(GRAY_CODED)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(ctrl.run),
        .load_we_i(load_we), .load_val_i(bus_wdata), .cnt_q(cnt)
    );

    sat_alarm #(.DATA_W(DATA_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .alarm_en_i(ctrl.alarm_en),
        .mask_i(mask), .cnt_i(cnt), .alarm_i(alarm_val), .clr_i(clr),
        .stat_o(stat), .irq_o(irq_o)
    );

    // Drive the reference select straight out of the control word.
    always_comb ref_sel_o = ctrl.ref_sel;
endmodule

// File: tb/test_sec_alarm_timer.sv
module test_sec_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = 6'h34;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_b, rdata_g;
    logic        ref_b, ref_g, irq_b, irq_g;

    int    checks = 0;
    int    errors = 0;
    bit    started = 1'b0;
    string phase = "R1";

    always #4 clk = ~clk;

    sec_alarm_timer #(.GRAY_CODED(1'b0)) i_sec_alarm_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .ref_sel_o(ref_b), .irq_o(irq_b));
    sec_alarm_timer #(.GRAY_CODED(1'b1)) i_sec_alarm_timer_gray (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_g), .ref_sel_o(ref_g), .irq_o(irq_g));

    // Behavioural model. Index 0 is the binary build, index 1 the Gray build.
    logic [31:0] m_cnt [2];
    logic [31:0] m_alarm [2];
    logic [31:0] m_ctrl [2];
    logic        m_mask [2];
    logic        m_stat [2];

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] r = g;
        for (int s = 1; s < 32; s = s * 2) r = r ^ (r >> s);
        return r;
    endfunction
    function automatic logic [31:0] step_val(input int k, input logic [31:0] v);
        if (k == 1) return to_gray(from_gray(v) + 32'd1);
        return v + 32'd1;
    endfunction
    function automatic logic [31:0] mread(input int k, input logic [5:0] a);
        case (a)
            6'h00: return m_ctrl[k];
            6'h04, 6'h34: return m_cnt[k];
            6'h08: return m_alarm[k];
            6'h20: return {31'd0, m_mask[k]};
            6'h30: return {31'd0, m_stat[k]};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_cnt[k] = 0; m_alarm[k] = 0; m_ctrl[k] = 0; m_mask[k] = 1; m_stat[k] = 0;
            end else begin
                logic hit, clr;
                logic [31:0] nc;
                hit = tick && m_ctrl[k][0] && (m_alarm[k] != 0) && (m_cnt[k] == m_alarm[k]);
                clr = bus_we && bus_addr == 6'h24 && bus_wdata[0];
                nc  = (bus_we && bus_addr == 6'h04) ? bus_wdata :
                      (tick && m_ctrl[k][12]) ? step_val(k, m_cnt[k]) : m_cnt[k];
                m_stat[k] = hit || (m_stat[k] && !clr);
                if (bus_we && bus_addr == 6'h00) m_ctrl[k] = bus_wdata & 32'h0000_1101;
                if (bus_we && bus_addr == 6'h08) m_alarm[k] = bus_wdata;
                if (bus_we && bus_addr == 6'h20) m_mask[k] = bus_wdata[0];
                m_cnt[k] = nc;
            end
        end
    end

    function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk({phase, " rdata bin"}, rdata_b, mread(0, bus_addr));
            chk({phase, " rdata gray"}, rdata_g, mread(1, bus_addr));
            chk({phase, " irq bin"}, {31'd0, irq_b}, {31'd0, m_stat[0] && m_ctrl[0][0] && !m_mask[0]});
            chk({phase, " irq gray"}, {31'd0, irq_g}, {31'd0, m_stat[1] && m_ctrl[1][0] && !m_mask[1]});
            chk({phase, " ref_sel"}, {31'd0, ref_b}, {31'd0, m_ctrl[0][8]});
        end
    end

    task automatic step(input logic we, input logic [5:0] a, input logic [31:0] d, input logic tk);
        @(posedge clk); #2;
        bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
    endtask
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0);
    endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 6'h34, 32'd0, 1'b1);
    endtask
    task automatic expect_rd(input string tag, input logic [5:0] a, input logic [31:0] exp_b);
        step(1'b0, a, 32'd0, 1'b0);
        @(negedge clk); #1;
        chk(tag, rdata_b, exp_b);
    endtask

    task automatic run_all();
        for (int i = 0; i < 3; i++) step(1'b0, 6'h34, 0, 1'b0);
        started = 1'b1;
        @(posedge clk); #2; rst_n = 1'b1;
        phase = "R1";
        expect_rd("R1 mask", 6'h20, 32'd1);
        expect_rd("R1 ctrl", 6'h00, 32'd0);
        expect_rd("R1 status", 6'h30, 32'd0);
        expect_rd("R1 time", 6'h34, 32'd0);
        chk("R1 irq", {31'd0, irq_b}, 32'd0);

        phase = "R2";
        wr(6'h00, 32'hFFFF_FFFF);
        expect_rd("R2 ctrl bits", 6'h00, 32'h0000_1101);
        chk("R2 ref_sel", {31'd0, ref_b}, 32'd1);
        wr(6'h00, 32'h0000_1000);

        phase = "R3";
        wr(6'h04, 32'd100);
        expect_rd("R3 load", 6'h34, 32'd100);
        step(1'b1, 6'h04, 32'd5, 1'b1);
        expect_rd("R3 load beats tick", 6'h04, 32'd5);

        phase = "R4";
        ticks(3);
        expect_rd("R4 three ticks", 6'h34, 32'd8);
        wr(6'h00, 32'h0);
        ticks(2);
        expect_rd("R4 halted", 6'h34, 32'd8);

        phase = "R5";
        wr(6'h00, 32'h0000_1000);
        wr(6'h04, 32'hFFFF_FFFE);
        ticks(2);
        expect_rd("R5 wrap", 6'h34, 32'd0);

        phase = "R6";
        wr(6'h04, 32'd0);
        ticks(5);
        expect_rd("R6 binary five", 6'h34, 32'd5);
        chk("R6 gray five", rdata_g, 32'h7);

        phase = "R7";
        wr(6'h08, 32'd10);
        wr(6'h20, 32'd0);
        wr(6'h00, 32'h0000_1001);
        wr(6'h04, 32'd8);
        ticks(2);
        expect_rd("R7 before match", 6'h30, 32'd0);
        ticks(1);
        expect_rd("R7 on match", 6'h30, 32'd1);
        ticks(4);
        expect_rd("R7 sticky", 6'h30, 32'd1);

        phase = "R9";
        chk("R9 irq live", {31'd0, irq_b}, 32'd1);
        wr(6'h20, 32'd1);
        expect_rd("R9 masked", 6'h30, 32'd1);
        chk("R9 masked irq", {31'd0, irq_b}, 32'd0);
        wr(6'h20, 32'd0);
        wr(6'h00, 32'h0000_1000);
        expect_rd("R9 disabled", 6'h30, 32'd1);
        chk("R9 disabled irq", {31'd0, irq_b}, 32'd0);

        phase = "R10";
        wr(6'h24, 32'hFFFF_FFFE);
        expect_rd("R10 zero write", 6'h30, 32'd1);
        wr(6'h24, 32'd1);
        expect_rd("R10 cleared", 6'h30, 32'd0);
        wr(6'h00, 32'h0000_1001);
        wr(6'h08, 32'd20);
        wr(6'h04, 32'd20);
        step(1'b1, 6'h24, 32'd1, 1'b1);
        expect_rd("R10 hit beats clear", 6'h30, 32'd1);

        phase = "R8";
        wr(6'h24, 32'd1);
        wr(6'h08, 32'd0);
        wr(6'h04, 32'd0);
        ticks(2);
        expect_rd("R8 zero alarm", 6'h30, 32'd0);

        phase = "R11";
        wr(6'h04, 32'd42);
        wr(6'h34, 32'hFFFF_FFFF);
        wr(6'h30, 32'hFFFF_FFFF);
        wr(6'h18, 32'hFFFF_FFFF);
        expect_rd("R11 time read-only", 6'h34, 32'd42);
        expect_rd("R11 status read-only", 6'h30, 32'd0);
        expect_rd("R11 unmapped", 6'h18, 32'd0);
        expect_rd("R11 unaligned", 6'h05, 32'd0);
        step(1'b0, 6'h34, 0, 1'b0);
        step(1'b0, 6'h34, 0, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule